// File: doc/BRIEF.md
# Single-Cycle DMA Transfer Sequencer

This block is the per-channel transfer engine of a legacy-style DMA controller. It watches the request lines of a small set of channels and takes the highest-priority one that is not masked. It asks the host for the bus and waits for the grant. It then runs one transfer, which is a single cycle of channel acknowledge with a memory strobe and an I/O strobe, and afterwards updates that channel's current address and remaining count.

A register file outside the block supplies the per-channel mode bits, the mask bits and the base address and count. It also pulses a load line that copies the base values into the current registers. The block returns the current values for readback. A loaded count of N gives N+1 transfers. The transfer that moves the count from zero to all-ones raises a terminal-count pulse and sets a sticky per-channel flag. On that transfer the channel either reloads from its base values or masks itself. The 16-bit address wraps and never carries outward. A channel in cascade mode does no transfers: it passes its request upward as the bus request and returns the grant as its acknowledge.

Top module: `xfer_sequencer`

## Requirements
- R1: After reset, busHold, every chanAck bit and all four strobes (memRd, memWr, ioRd, ioWr) are 0, and every selfMask and tcFlags bit is 0.
- R2: When several unmasked channels request in the same idle cycle, the lowest-numbered channel is served (channel 0 has highest priority).
- R3: A request on a channel whose chanMask bit is 1 is ignored: busHold stays 0 and the channel's current count is unchanged.
- R4: busHold rises on the clock edge after a request is sampled in the idle state. While busGrant is low, no chanAck bit is set. On the edge where busGrant is seen high, the served channel's chanAck bit is set for exactly one cycle.
- R5: A loaded count of N gives N+1 transfers. termCount is 1 only during the transfer made while the current count is 0x0000. After that transfer, without auto-initialise, curCnt reads 0xFFFF.
- R6: xferAddr during the k-th transfer (k from 0) equals the loaded base address plus k, modulo 2^16. After each transfer curAddr is incremented modulo 2^16 (0xFFFF is followed by 0x0000).
- R7: With modeAutoInit set, the terminal-count transfer reloads curAddr and curCnt from baseAddr and baseCnt, and selfMask stays 0.
- R8: Without modeAutoInit, the terminal-count transfer sets the channel's selfMask bit. Further requests on that channel are ignored until a load pulse clears it.
- R9: During a transfer with modeDirToMem=1, memWr and ioRd are 1 and memRd and ioWr are 0. With modeDirToMem=0 it is the reverse: memRd and ioWr are 1.
- R10: A channel with modeCascade set drives busHold equal to its request and its chanAck equal to busGrant. No strobe is raised and its address and count do not change.
- R11: The terminal-count transfer sets the channel's tcFlags bit, which stays set until the next load pulse for that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| chanReq | input | NUM_CH | Per-channel transfer request |
| chanMask | input | NUM_CH | Per-channel mask from the register file (1 = masked) |
| modeAutoInit | input | NUM_CH | Reload from base at terminal count |
| modeDirToMem | input | NUM_CH | 1 = I/O to memory, 0 = memory to I/O |
| modeCascade | input | NUM_CH | Pass request and grant through, no transfers |
| loadStrobe | input | NUM_CH | Copy base into current, clear selfMask and tcFlags |
| baseAddr | input | NUM_CH x ADDR_W | Per-channel base address |
| baseCnt | input | NUM_CH x CNT_W | Per-channel base count (transfers minus one) |
| busGrant | input | 1 | Bus grant from the host |
| busHold | output | 1 | Bus request to the host |
| chanAck | output | NUM_CH | Per-channel acknowledge |
| memRd | output | 1 | Memory read strobe |
| memWr | output | 1 | Memory write strobe |
| ioRd | output | 1 | I/O read strobe |
| ioWr | output | 1 | I/O write strobe |
| xferAddr | output | ADDR_W | Address of the transfer in progress |
| termCount | output | 1 | Terminal-count pulse, high during the last transfer |
| curAddr | output | NUM_CH x ADDR_W | Current address readback |
| curCnt | output | NUM_CH x CNT_W | Current count readback |
| tcFlags | output | NUM_CH | Sticky terminal-count status |
| selfMask | output | NUM_CH | Mask set by the channel itself at terminal count |

## Verification
A wrong count or address in one channel shows at the ports on the next transfer of that channel. It appears in xferAddr during the acknowledge cycle, or in curCnt two cycles after the acknowledge, when the update has landed. A broken terminal-count decision shows up as a transfer sequence of the wrong length, a missing or early termCount pulse, or a selfMask and tcFlags state that does not match the mode. The bench sweeps every channel over a range of small counts, with and without auto-initialise, and checks every transfer. A wrong arbitration or sequencer state shows within a handful of cycles, as the wrong chanAck bit, a bus request on a masked channel, or an acknowledge issued before the grant.

// File: rtl/xfer_seq_pkg.sv
package xfer_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_REQ  = 3'd1,
    S_XFER = 3'd2,
    S_UPD  = 3'd3,
    S_CASC = 3'd4
  } seqState_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic xferNow;   // acknowledge cycle of a transfer
    logic updNow;    // register update cycle
  } seqStrobe_t;

endpackage

// File: rtl/seq_control.sv
module seq_control
  import xfer_seq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int SEL_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chanReq,
  input  logic [NUM_CH-1:0] effMask,
  input  logic [NUM_CH-1:0] modeCascade,
  input  logic              busGrant,
  output seqStrobe_t        strobe,
  output logic [SEL_W-1:0]  sel,
  output logic              busHold,
  output logic [NUM_CH-1:0] chanAck
);

  seqState_t        state, stateNext;
  logic [SEL_W-1:0] selQ, pick;
  logic             anyLive;
  logic [NUM_CH-1:0] live;

  assign live = chanReq & ~effMask;

  // Fixed priority: scan high to low so the lowest index wins
  always_comb begin
    pick    = '0;
    anyLive = 1'b0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (live[i]) begin
        pick    = SEL_W'(i);
        anyLive = 1'b1;
      end
    end
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE: if (anyLive) stateNext = modeCascade[pick] ? S_CASC : S_REQ;
      S_REQ:  if (busGrant) stateNext = S_XFER;
      S_XFER: stateNext = S_UPD;
      S_UPD:  stateNext = S_IDLE;
      S_CASC: if (!chanReq[selQ]) stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      selQ  <= '0;
    end else begin
      state <= stateNext;
      if (state == S_IDLE && anyLive) selQ <= pick;
    end
  end

  always_comb begin
    chanAck = '0;
    if (state == S_XFER) chanAck[selQ] = 1'b1;
    if (state == S_CASC) chanAck[selQ] = busGrant;
  end

  assign busHold        = (state == S_REQ) || (state == S_XFER) ||
                          ((state == S_CASC) && chanReq[selQ]);
  assign strobe.xferNow = (state == S_XFER);
  assign strobe.updNow  = (state == S_UPD);
  assign sel            = selQ;

  // R4: at most one channel acknowledged
  p_onehot_ack_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chanAck));

  // R4: a transfer cycle only follows a seen grant
  p_xfer_granted_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_XFER) |-> $past(busGrant));

  // R3: with nothing unmasked requesting, idle stays idle
  p_masked_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && live == '0) |=> (state == S_IDLE));

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import xfer_seq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int SEL_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  seqStrobe_t                    strobe,
  input  logic [SEL_W-1:0]              sel,
  input  logic [NUM_CH-1:0]             loadStrobe,
  input  logic [NUM_CH-1:0]             modeAutoInit,
  input  logic [NUM_CH-1:0][ADDR_W-1:0] baseAddr,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  baseCnt,
  output logic [NUM_CH-1:0][ADDR_W-1:0] curAddr,
  output logic [NUM_CH-1:0][CNT_W-1:0]  curCnt,
  output logic [NUM_CH-1:0]             tcFlags,
  output logic [NUM_CH-1:0]             selfMask,
  output logic [ADDR_W-1:0]             xferAddr,
  output logic                          termCount
);

  logic atZero;
  assign atZero    = (curCnt[sel] == '0);
  assign xferAddr  = curAddr[sel];
  assign termCount = strobe.xferNow && atZero;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic hit, lastOne;
    assign hit     = strobe.updNow && (sel == SEL_W'(g));
    assign lastOne = (curCnt[g] == '0);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        curAddr[g]  <= '0;
        curCnt[g]   <= '0;
        tcFlags[g]  <= 1'b0;
        selfMask[g] <= 1'b0;
      end else if (loadStrobe[g]) begin
        curAddr[g]  <= baseAddr[g];
        curCnt[g]   <= baseCnt[g];
        tcFlags[g]  <= 1'b0;
        selfMask[g] <= 1'b0;
      end else if (hit) begin
        if (lastOne) begin
          tcFlags[g] <= 1'b1;
          if (modeAutoInit[g]) begin
            curAddr[g] <= baseAddr[g];
            curCnt[g]  <= baseCnt[g];
          end else begin
            curAddr[g]  <= curAddr[g] + 1'b1;
            curCnt[g]   <= curCnt[g] - 1'b1;
            selfMask[g] <= 1'b1;
          end
        end else begin
          curAddr[g] <= curAddr[g] + 1'b1;
          curCnt[g]  <= curCnt[g] - 1'b1;
        end
      end
    end
  end

  // R5: terminal count only appears inside a transfer cycle
  p_tc_in_xfer_r5: assert property (@(posedge clk) disable iff (!rstN)
    termCount |-> strobe.xferNow);

  // R5: last non-reloading update leaves all-ones in the count
  p_tc_readback_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.updNow && atZero && !modeAutoInit[sel] && !loadStrobe[sel])
      |=> (curCnt[$past(sel)] == '1));

  // R8: same event masks the channel
  p_self_mask_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.updNow && atZero && !modeAutoInit[sel] && !loadStrobe[sel])
      |=> selfMask[$past(sel)]);

endmodule

// File: rtl/xfer_sequencer.sv
module xfer_sequencer
  import xfer_seq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_CH-1:0]             chanReq,
  input  logic [NUM_CH-1:0]             chanMask,
  input  logic [NUM_CH-1:0]             modeAutoInit,
  input  logic [NUM_CH-1:0]             modeDirToMem,
  input  logic [NUM_CH-1:0]             modeCascade,
  input  logic [NUM_CH-1:0]             loadStrobe,
  input  logic [NUM_CH-1:0][ADDR_W-1:0] baseAddr,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  baseCnt,
  input  logic                          busGrant,
  output logic                          busHold,
  output logic [NUM_CH-1:0]             chanAck,
  output logic                          memRd,
  output logic                          memWr,
  output logic                          ioRd,
  output logic                          ioWr,
  output logic [ADDR_W-1:0]             xferAddr,
  output logic                          termCount,
  output logic [NUM_CH-1:0][ADDR_W-1:0] curAddr,
  output logic [NUM_CH-1:0][CNT_W-1:0]  curCnt,
  output logic [NUM_CH-1:0]             tcFlags,
  output logic [NUM_CH-1:0]             selfMask
);

  seqStrobe_t       strobe;
  logic [SEL_W-1:0] sel;
  logic             toMem;

  seq_control #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .chanReq(chanReq),
    .effMask(chanMask | selfMask), .modeCascade(modeCascade),
    .busGrant(busGrant), .strobe(strobe), .sel(sel),
    .busHold(busHold), .chanAck(chanAck)
  );

  seq_datapath #(.NUM_CH(NUM_CH), .SEL_W(SEL_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sel(sel),
    .loadStrobe(loadStrobe), .modeAutoInit(modeAutoInit),
    .baseAddr(baseAddr), .baseCnt(baseCnt),
    .curAddr(curAddr), .curCnt(curCnt), .tcFlags(tcFlags),
    .selfMask(selfMask), .xferAddr(xferAddr), .termCount(termCount)
  );

  assign toMem = modeDirToMem[sel];
  assign memWr = strobe.xferNow &&  toMem;
  assign ioRd  = strobe.xferNow &&  toMem;
  assign memRd = strobe.xferNow && !toMem;
  assign ioWr  = strobe.xferNow && !toMem;

  // R9: strobes only with an acknowledge, never both memory strobes
  p_strobe_ack_r9: assert property (@(posedge clk) disable iff (!rstN)
    (memRd || memWr) |-> ((chanAck != '0) && !(memRd && memWr)));

  // R10: cascade acknowledge never comes with strobes
  p_cascade_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((chanAck & modeCascade) != '0) |-> !(memRd || memWr || ioRd || ioWr));

endmodule

// File: tb/test_xfer_sequencer.sv
module test_xfer_sequencer;
  localparam int NC = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic [NC-1:0] chanReq = '0, chanMask = '0, modeAutoInit = '0;
  logic [NC-1:0] modeDirToMem = '0, modeCascade = '0, loadStrobe = '0;
  logic [NC-1:0][15:0] baseAddr = '0, baseCnt = '0;
  logic busGrant = 1'b1;
  logic busHold, memRd, memWr, ioRd, ioWr, termCount;
  logic [NC-1:0] chanAck, tcFlags, selfMask;
  logic [15:0] xferAddr;
  logic [NC-1:0][15:0] curAddr, curCnt;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  xfer_sequencer i_xfer_sequencer (
    .clk, .rstN, .chanReq, .chanMask, .modeAutoInit, .modeDirToMem,
    .modeCascade, .loadStrobe, .baseAddr, .baseCnt, .busGrant, .busHold,
    .chanAck, .memRd, .memWr, .ioRd, .ioWr, .xferAddr, .termCount,
    .curAddr, .curCnt, .tcFlags, .selfMask);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic doLoad(input int ch);
    @(negedge clk); loadStrobe[ch] = 1'b1;
    @(negedge clk); loadStrobe[ch] = 1'b0;
  endtask

  // Raise a request set, return the acknowledged vector and transfer outputs
  task automatic serve(input logic [NC-1:0] reqs, output logic [NC-1:0] ack,
                       output logic [15:0] addr, output logic [3:0] strb,
                       output logic tc);
    ack = '0; addr = '0; strb = '0; tc = 1'b0;
    @(negedge clk); chanReq = reqs;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (chanAck != '0) break;
    end
    ack = chanAck; addr = xferAddr; tc = termCount;
    strb = {memRd, memWr, ioRd, ioWr};
    chanReq = '0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic noService(input int ch, input string req);
    bit seen = 0;
    @(negedge clk); chanReq[ch] = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (busHold) seen = 1;
    end
    chanReq[ch] = 1'b0;
    chk(!seen, req, "busHold on ignored request", {31'd0, seen}, 32'd0);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(0, "WD", "watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [NC-1:0] ack;
    logic [15:0] a;
    logic [3:0] s;
    logic tc;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busHold && chanAck == '0 && {memRd, memWr, ioRd, ioWr} == 0, "R1",
        "outputs at reset", {busHold, chanAck, memRd, memWr, ioRd, ioWr}, 0);
    chk(selfMask == '0 && tcFlags == '0, "R1", "flags at reset",
        {selfMask, tcFlags}, 0);
    rstN = 1'b1;

    // Sweep: every channel, counts 0..3, auto-init on count 2
    for (int ch = 0; ch < NC; ch++) begin
      for (int n = 0; n < 4; n++) begin
        logic [15:0] b;
        bit au, dir;
        b  = (ch == 1) ? 16'hFFFE : 16'(16'h1000 * ch + 16'h10 * n);
        au = (n == 2);
        dir = ch[0];
        baseAddr[ch] = b; baseCnt[ch] = 16'(n);
        modeAutoInit[ch] = au; modeDirToMem[ch] = dir;
        doLoad(ch);
        for (int i = 0; i <= n; i++) begin
          serve(NC'(1) << ch, ack, a, s, tc);
          chk(ack == (NC'(1) << ch), "R4", "ack channel", ack, NC'(1) << ch);
          chk(a == 16'(b + i), "R6", "transfer address", a, 16'(b + i));
          chk(tc == (i == n), "R5", "termCount", tc, (i == n));
          chk(s == (dir ? 4'b0110 : 4'b1001), "R9", "strobes", s,
              dir ? 4'b0110 : 4'b1001);
        end
        chk(tcFlags[ch], "R11", "tc flag set", tcFlags[ch], 1);
        if (au) begin
          chk(curAddr[ch] == b && curCnt[ch] == 16'(n), "R7", "reload",
              {curAddr[ch], curCnt[ch]}, {b, 16'(n)});
          chk(!selfMask[ch], "R7", "no self mask", selfMask[ch], 0);
        end else begin
          chk(curCnt[ch] == 16'hFFFF, "R5", "count readback", curCnt[ch], 16'hFFFF);
          chk(curAddr[ch] == 16'(b + n + 1), "R6", "final address",
              curAddr[ch], 16'(b + n + 1));
          chk(selfMask[ch], "R8", "self mask set", selfMask[ch], 1);
          noService(ch, "R8");
        end
      end
    end
    modeAutoInit = '0;

    // Priority: all channels loaded with count 5
    for (int ch = 0; ch < NC; ch++) begin
      baseAddr[ch] = 16'(16'h4000 + ch); baseCnt[ch] = 16'd5; doLoad(ch);
    end
    chk(tcFlags == '0 && selfMask == '0, "R11", "load clears flags",
        {tcFlags, selfMask}, 0);
    serve(4'b1111, ack, a, s, tc);
    chk(ack == 4'b0001, "R2", "ch0 wins", ack, 4'b0001);
    serve(4'b1110, ack, a, s, tc);
    chk(ack == 4'b0010, "R2", "ch1 wins", ack, 4'b0010);
    serve(4'b1100, ack, a, s, tc);
    chk(ack == 4'b0100, "R2", "ch2 wins", ack, 4'b0100);
    chanMask = 4'b0011;
    serve(4'b1011, ack, a, s, tc);
    chk(ack == 4'b1000, "R3", "masked ch0/1 skipped", ack, 4'b1000);

    // R3 masked request has no effect
    chanMask = 4'b0100;
    noService(2, "R3");
    chk(curCnt[2] == 16'd4, "R3", "masked count unchanged", curCnt[2], 4);
    chanMask = '0;

    // R4 grant delay
    busGrant = 1'b0;
    @(negedge clk); chanReq[0] = 1'b1;
    repeat (3) @(negedge clk);
    chk(busHold, "R4", "busHold raised", busHold, 1);
    chk(chanAck == '0, "R4", "no ack before grant", chanAck, 0);
    busGrant = 1'b1;
    @(negedge clk);
    chk(chanAck == 4'b0001, "R4", "ack after grant", chanAck, 4'b0001);
    chanReq[0] = 1'b0;
    @(negedge clk);
    chk(chanAck == '0, "R4", "ack one cycle", chanAck, 0);
    @(negedge clk);

    // R10 cascade
    modeCascade[3] = 1'b1; busGrant = 1'b0;
    @(negedge clk); chanReq[3] = 1'b1;
    repeat (2) @(negedge clk);
    chk(busHold, "R10", "request forwarded", busHold, 1);
    chk(chanAck == '0, "R10", "no ack without grant", chanAck, 0);
    busGrant = 1'b1; #1;
    chk(chanAck == 4'b1000, "R10", "grant returned", chanAck, 4'b1000);
    chk({memRd, memWr, ioRd, ioWr} == 0, "R10", "no strobes",
        {memRd, memWr, ioRd, ioWr}, 0);
    @(negedge clk); chanReq[3] = 1'b0; #1;
    chk(!busHold, "R10", "hold follows request", busHold, 0);
    repeat (2) @(negedge clk);
    chk(curCnt[3] == 16'd4 && curAddr[3] == 16'h4004, "R10", "no count change",
        {curAddr[3], curCnt[3]}, {16'h4004, 16'd4});
    modeCascade = '0;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule